// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand address for an 8-bit controller core that keeps a 16-bit index pair and a 16-bit stack pointer. Each clock it samples a three-bit addressing-mode code, the current index and stack pointer, and up to two offset bytes from the instruction stream. One cycle later it presents a 16-bit effective address. For the two post-increment modes it also presents an incremented index value with a write strobe, so the core can update the index pair.

Every 8-bit offset is treated as unsigned, meaning it is zero-extended. Every sum wraps modulo 65536, and no carry is reported. Fetch, decode and the memory access itself belong to the surrounding core.

Top module: `idx_ea_gen`

## Requirements
- R1: While `rst_n` is low, `ea`, `hx_next` and `hx_wr` are all zero.
- R2: Inputs are sampled on a rising clock edge, and the matching outputs hold from that edge until the next one. The outputs do not change between edges.
- R3: Mode code 0 (index, no offset) gives `ea` equal to `hx`.
- R4: Mode code 1 (index, byte offset) gives `ea` = `hx` + {8'h00, `off_lo`}.
- R5: Mode code 2 (index, word offset) gives `ea` = `hx` + {`off_hi`, `off_lo`}.
- R6: Mode code 3 gives `ea` = `sp` + {8'h00, `off_lo`}. Mode code 4 gives `ea` = `sp` + {`off_hi`, `off_lo`}.
- R7: Mode code 5 (pointer post-increment) gives `ea` = `hx`, `hx_next` = `hx` + 1 and `hx_wr` = 1.
- R8: Mode code 6 (byte offset, then post-increment) gives `ea` = `hx` + {8'h00, `off_lo`}, `hx_next` = `hx` + 1 and `hx_wr` = 1.
- R9: Mode code 7 (page zero) gives `ea` = {8'h00, `off_lo`}.
- R10: Every address and increment sum wraps modulo 2^16.
- R11: For mode codes 0 to 4 and 7, `hx_wr` is 0 and `hx_next` equals the sampled `hx`.
- R12: `off_hi` has no effect on the outputs in mode codes 0, 1, 3, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Addressing-mode code (0 to 7, see R3 to R9) |
| hx | input | 16 | Current index pair |
| sp | input | 16 | Current stack pointer |
| off_hi | input | 8 | Upper offset byte |
| off_lo | input | 8 | Lower offset byte, or page-zero operand |
| ea | output | 16 | Effective address |
| hx_next | output | 16 | Index write-back value |
| hx_wr | output | 1 | Index write-back enable |

## Verification
In mode 6, address formation and index write-back happen in the same cycle. Both are computed from one sampled `hx` but take different paths: the address adds the offset, and the write-back adds one. The bench provokes this with `hx` = 0xFFFF and `off_lo` = 0xFF. It then expects the address to wrap to 0x00FE and the write-back value to wrap to 0x0000, with the strobe high, on the same edge. Mode 5 with `hx` = 0xFFFF is checked in the same way, where the address stays at 0xFFFF while the write-back value wraps.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned BW = 8;

  typedef enum logic [2:0] {
    M_IDX      = 3'd0,
    M_IDX_B    = 3'd1,
    M_IDX_W    = 3'd2,
    M_STK_B    = 3'd3,
    M_STK_W    = 3'd4,
    M_PINC     = 3'd5,
    M_PINC_B   = 3'd6,
    M_PAGE0    = 3'd7
  } ea_mode_e;

  // widen an unsigned byte to an address
  function automatic logic [AW-1:0] widen_byte(input logic [BW-1:0] b);
    return {{(AW-BW){1'b0}}, b};
  endfunction

  // join two offset bytes into a word
  function automatic logic [AW-1:0] join_word(input logic [BW-1:0] hi, input logic [BW-1:0] lo);
    return {hi, lo};
  endfunction

  // modular address sum with carry out
  function automatic logic [AW:0] wrap_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic is_post_inc(input logic [2:0] m);
    return (m == M_PINC) || (m == M_PINC_B);
  endfunction
endpackage

// File: rtl/eag_operand_sel.sv
module eag_operand_sel
  import eag_pkg::*;
(
  input  logic [2:0]    mode,
  input  logic [AW-1:0] hx,
  input  logic [AW-1:0] sp,
  input  logic [BW-1:0] off_hi,
  input  logic [BW-1:0] off_lo,
  output logic [AW-1:0] base,
  output logic [AW-1:0] offset
);
  always_comb begin
    base   = hx;
    offset = '0;
    unique case (ea_mode_e'(mode))
      M_IDX:    begin base = hx; offset = '0;                       end
      M_IDX_B:  begin base = hx; offset = widen_byte(off_lo);       end
      M_IDX_W:  begin base = hx; offset = join_word(off_hi, off_lo); end
      M_STK_B:  begin base = sp; offset = widen_byte(off_lo);       end
      M_STK_W:  begin base = sp; offset = join_word(off_hi, off_lo); end
      M_PINC:   begin base = hx; offset = '0;                       end
      M_PINC_B: begin base = hx; offset = widen_byte(off_lo);       end
      M_PAGE0:  begin base = '0; offset = widen_byte(off_lo);       end
      default:  begin base = hx; offset = '0;                       end
    endcase
  end
endmodule

// File: rtl/eag_adder.sv
module eag_adder
  import eag_pkg::*;
(
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] sum,
  output logic          wrap_evt
);
  logic [AW:0] full;
  always_comb begin
    full     = wrap_add(base, offset);
    sum      = full[AW-1:0];
    wrap_evt = full[AW];
  end
endmodule

// File: rtl/eag_writeback.sv
module eag_writeback
  import eag_pkg::*;
(
  input  logic [2:0]    mode,
  input  logic [AW-1:0] hx,
  output logic [AW-1:0] nx,
  output logic          wr
);
  logic [AW:0] bumped;
  always_comb begin
    bumped = wrap_add(hx, widen_byte(8'd1));
    wr     = is_post_inc(mode);
    nx     = wr ? bumped[AW-1:0] : hx;
  end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import eag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic [15:0]   hx,
  input  logic [15:0]   sp,
  input  logic [7:0]    off_hi,
  input  logic [7:0]    off_lo,
  output logic [15:0]   ea,
  output logic [15:0]   hx_next,
  output logic          hx_wr
);
  logic [AW-1:0] sel_base, sel_off, addr_d, nx_d;
  logic          wr_d, addr_wrap;

  eag_operand_sel u_sel (
    .mode(mode), .hx(hx), .sp(sp), .off_hi(off_hi), .off_lo(off_lo),
    .base(sel_base), .offset(sel_off)
  );

  eag_adder u_add (
    .base(sel_base), .offset(sel_off), .sum(addr_d), .wrap_evt(addr_wrap)
  );

  eag_writeback u_wb (
    .mode(mode), .hx(hx), .nx(nx_d), .wr(wr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea      <= '0;
      hx_next <= '0;
      hx_wr   <= 1'b0;
    end else begin
      ea      <= addr_d;
      hx_next <= nx_d;
      hx_wr   <= wr_d;
    end
  end

  // R7
  post_inc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hx_wr |-> (hx_next == $past(hx) + 16'd1));

  // R11
  wr_only_post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hx_wr |-> ($past(mode) == 3'd5 || $past(mode) == 3'd6));

  // R9
  page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == 3'd7) |-> (ea == {8'h00, $past(off_lo)}));

  // R3
  plain_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == 3'd0) |-> (ea == $past(hx)));

  // R10
  byte_off_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == 3'd1) |-> (ea == $past(hx) + {8'h00, $past(off_lo)}));
endmodule

// File: tb/idx_ea_gen_test.sv
module idx_ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] hx = '0, sp = '0;
  logic [7:0]  off_hi = '0, off_lo = '0;
  logic [15:0] ea, hx_next;
  logic        hx_wr;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  idx_ea_gen uut (.clk(clk), .rst_n(rst_n), .mode(mode), .hx(hx), .sp(sp),
    .off_hi(off_hi), .off_lo(off_lo), .ea(ea), .hx_next(hx_next), .hx_wr(hx_wr));

  // {mode, hx, sp, off_hi, off_lo, exp_ea, exp_nx, exp_wr}
  localparam int N = 19;
  localparam logic [83:0] VEC [N] = '{
    {3'd0, 16'h1234, 16'h8000, 8'hAA, 8'h55, 16'h1234, 16'h1234, 1'b0},
    {3'd0, 16'hFFFF, 16'h0000, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 1'b0},
    {3'd1, 16'h1234, 16'h0000, 8'h00, 8'h00, 16'h1234, 16'h1234, 1'b0},
    {3'd1, 16'h1234, 16'h0000, 8'h77, 8'hFF, 16'h1333, 16'h1234, 1'b0},
    {3'd1, 16'hFFFF, 16'h0000, 8'h00, 8'hFF, 16'h00FE, 16'hFFFF, 1'b0},
    {3'd2, 16'h1000, 16'h0000, 8'h12, 8'h34, 16'h2234, 16'h1000, 1'b0},
    {3'd2, 16'hFFFF, 16'h0000, 8'h00, 8'hFF, 16'h00FE, 16'hFFFF, 1'b0},
    {3'd2, 16'hFF00, 16'h0000, 8'h01, 8'h00, 16'h0000, 16'hFF00, 1'b0},
    {3'd3, 16'h4321, 16'h01F0, 8'h99, 8'h0F, 16'h01FF, 16'h4321, 1'b0},
    {3'd3, 16'h0000, 16'hFFFF, 8'h00, 8'hFF, 16'h00FE, 16'h0000, 1'b0},
    {3'd4, 16'h0000, 16'h0100, 8'h80, 8'h00, 16'h8100, 16'h0000, 1'b0},
    {3'd4, 16'h0000, 16'hFFF0, 8'h00, 8'h20, 16'h0010, 16'h0000, 1'b0},
    {3'd5, 16'h00FF, 16'h0000, 8'h12, 8'h34, 16'h00FF, 16'h0100, 1'b1},
    {3'd5, 16'hFFFF, 16'h0000, 8'h00, 8'h00, 16'hFFFF, 16'h0000, 1'b1},
    {3'd6, 16'h2000, 16'h0000, 8'hEE, 8'h00, 16'h2000, 16'h2001, 1'b1},
    {3'd6, 16'hFFFF, 16'h0000, 8'h00, 8'hFF, 16'h00FE, 16'h0000, 1'b1},
    {3'd7, 16'hABCD, 16'h1234, 8'h56, 8'h80, 16'h0080, 16'hABCD, 1'b0},
    {3'd7, 16'hABCD, 16'h1234, 8'h00, 8'hFF, 16'h00FF, 16'hABCD, 1'b0},
    {3'd7, 16'hFFFF, 16'hFFFF, 8'hFF, 8'h00, 16'h0000, 16'hFFFF, 1'b0}
  };

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [15:0] h, input logic [15:0] s,
                       input logic [7:0] oh, input logic [7:0] ol);
    mode = m; hx = h; sp = s; off_hi = oh; off_lo = ol;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    // R1: outputs held at zero during reset even with active inputs
    drive(3'd5, 16'h7777, 16'h1111, 8'h22, 8'h33);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ea in reset", ea, 16'h0000);
    check("R1", "hx_next in reset", hx_next, 16'h0000);
    check("R1", "hx_wr in reset", {15'd0, hx_wr}, 16'h0000);
    rst_n = 1'b1;

    // table walk: drive at falling edge, sample at next falling edge
    for (int i = 0; i < N; i++) begin
      logic [83:0] v;
      v = VEC[i];
      drive(v[83:81], v[80:65], v[64:49], v[48:41], v[40:33]);
      @(posedge clk);
      @(negedge clk);
      check(req_of(v[83:81]), "ea", ea, v[32:17]);
      // R11 for non post-increment codes, R7/R8 otherwise
      check(req_of(v[83:81]), "hx_next", hx_next, v[16:1]);
      check(req_of(v[83:81]), "hx_wr", {15'd0, hx_wr}, {15'd0, v[0]});
    end

    // R2: change inputs, outputs must hold until the next edge
    drive(3'd0, 16'h5A5A, 16'h0000, 8'h00, 8'h00);
    @(posedge clk); @(negedge clk);
    drive(3'd0, 16'hA5A5, 16'h0000, 8'h00, 8'h00);
    #5;
    check("R2", "ea before edge", ea, 16'h5A5A);
    @(posedge clk); @(negedge clk);
    check("R2", "ea after edge", ea, 16'hA5A5);

    // R12: off_hi varied in byte mode must not move the address
    drive(3'd3, 16'h0000, 16'h2000, 8'hFF, 8'h10);
    @(posedge clk); @(negedge clk);
    check("R12", "ea stack byte with off_hi=FF", ea, 16'h2010);
    drive(3'd6, 16'h3000, 16'h0000, 8'hFF, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R12", "ea post-inc byte with off_hi=FF", ea, 16'h3001);

    // R10: both paths wrap in one cycle (mode 6, hx=FFFF, off 0xFF)
    drive(3'd6, 16'hFFFF, 16'hFFFF, 8'h00, 8'hFF);
    @(posedge clk); @(negedge clk);
    check("R10", "ea wrap", ea, 16'h00FE);
    check("R10", "hx_next wrap", hx_next, 16'h0000);

    // R1: reset mid-run clears outputs
    drive(3'd5, 16'h1234, 16'h0000, 8'h00, 8'h00);
    @(posedge clk); @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1", "ea after reset", ea, 16'h0000);
    check("R1", "hx_wr after reset", {15'd0, hx_wr}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule